// File: doc/BRIEF.md
# Reduced-Table Constant Multiplier

This block multiplies a 5-bit unsigned operand by a coefficient that is fixed when the block is built. It has no multiplier array. It keeps a table of just eight words: the odd multiples 1, 3, 5 … 15 of the coefficient. Every other product is rebuilt from one of those words in four ways:

- operand values above 16 are folded around 16;
- an encoder turns the folded value into a table index and a shift count;
- a left shifter of 0 to 3 places restores the even multiples;
- a zero gate handles an operand of 0.

An operand of exactly 16 is served directly as the coefficient shifted left by four. For a folded operand, the final stage subtracts the rebuilt product from 32 times the coefficient. Otherwise it passes the product through. The result is registered, so it appears one clock after the operand is presented. The block is meant to be used where one input is multiplied by a constant tap weight, as in a filter.

Top module: `odd_lut_cmul`

## Requirements
- R1: `prod` equals `x * COEF`, zero-extended to W+5 bits, for every 5-bit `x`. It is registered, and the operand sampled at one rising edge is reflected at that edge.
- R2: While `rst_n` is low, `prod` is 0 whatever `x` is.
- R3: The table holds the eight odd multiples 1·COEF to 15·COEF, one per index 0 to 7 (index i holds (2i+1)·COEF). Odd operands 1 to 15 read entry (x-1)/2 with no shift.
- R4: An even operand 2 to 14, written 2^k·m with m odd, reads entry (m-1)/2 and is shifted left by k (k is 1 to 3).
- R5: An operand of 0 gives a product of 0 through the zero gate. No table word is selected.
- R6: An operand of 16 gives 16·COEF without a table read.
- R7: An operand of 17 to 31 gives 32·COEF minus (32-x)·COEF.
- R8: The result is exact for a coefficient of 0 (all products 0) and for the largest W-bit coefficient. No result overflows W+5 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| x | input | 5 | Unsigned multiplier operand |
| prod | output | W+5 | Registered product x·COEF |

## Verification
Every result is due exactly one rising edge after its operand. The bench changes `x` on a falling edge and reads `prod` on the next falling edge. That places each sample half a period after the single register that captures it. Operands are changed on every cycle, back to back, so a stale or early result shows up as a miscompare. The reset check reads `prod` on falling edges while reset is held, with a nonzero operand applied.

// File: rtl/odd_lut_cmul.sv
module odd_lut_cmul #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] COEF = W'(173)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [4:0]     x,
  output logic [W+4:0]   prod
);
  localparam int TW = W + 4;
  localparam int PW = W + 5;

  logic [TW-1:0] odd_tbl [8];
  logic          fold, sixteen, zero;
  logic [3:0]    xf;
  logic [2:0]    idx;
  logic [1:0]    k;
  logic [7:0]    sel;
  logic [TW-1:0] word, shifted, mag;
  logic [PW-1:0] res;

  // odd multiples 1A..15A
  for (genvar g = 0; g < 8; g++) begin : g_tbl
    assign odd_tbl[g] = TW'(COEF) * TW'(2 * g + 1);
  end

  // anti-symmetric fold around 16
  assign fold    = x[4] & (|x[3:0]);
  assign sixteen = (x == 5'd16);
  assign xf      = fold ? 4'(5'd0 - x) : x[3:0];
  assign zero    = (xf == 4'd0) & ~sixteen;

  // 4-to-3 address encoder plus shift control
  always_comb begin
    casez (xf)
      4'b???1: begin idx = xf[3:1];         k = 2'd0; end
      4'b??10: begin idx = {1'b0, xf[3:2]}; k = 2'd1; end
      4'b?100: begin idx = {2'b0, xf[3]};   k = 2'd2; end
      4'b1000: begin idx = 3'd0;            k = 2'd3; end
      default: begin idx = 3'd0;            k = 2'd0; end
    endcase
  end

  // 3-to-8 decoder, word lines held off for zero and sixteen
  assign sel = (zero | sixteen) ? 8'd0 : (8'd1 << idx);

  always_comb begin
    word = '0;
    for (int i = 0; i < 8; i++)
      if (sel[i]) word = word | odd_tbl[i];
  end

  // barrel shifter of 4:1 muxes
  always_comb begin
    case (k)
      2'd0:    shifted = word;
      2'd1:    shifted = {word[TW-2:0], 1'b0};
      2'd2:    shifted = {word[TW-3:0], 2'b0};
      default: shifted = {word[TW-4:0], 3'b0};
    endcase
  end

  // zero gate and direct 16A path
  assign mag = zero ? '0 : (sixteen ? {COEF, 4'b0} : shifted);

  // restore the folded half
  assign res = fold ? ({COEF, 5'b0} - PW'(mag)) : PW'(mag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prod <= '0;
    else        prod <= res;
  end

  p_prod_exact_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> prod == PW'(PW'($past(x)) * PW'(COEF)));

  p_reset_clear_r2: assert property (@(posedge clk)
    !rst_n |-> prod == '0);

  p_onehot_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));

  p_zero_noread_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (x == 5'd0) |-> (sel == 8'd0 && mag == '0));

  p_sixteen_noread_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (x == 5'd16) |-> sel == 8'd0);

  p_fold_sum_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(x) > 5'd16) |->
      PW'(prod + PW'(PW'(6'd32 - $past(x)) * PW'(COEF))) == PW'({COEF, 5'b0}));
endmodule

// File: tb/odd_lut_cmul_bench.sv
module odd_lut_cmul_bench;
  localparam int W  = 8;
  localparam int PW = W + 5;
  localparam logic [W-1:0] C_MAIN = 8'd173;
  localparam logic [W-1:0] C_ZERO = 8'd0;
  localparam logic [W-1:0] C_MAX  = 8'd255;
  localparam logic [W-1:0] C_ONE  = 8'd1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] x = 5'd21;
  logic [PW-1:0] p_main, p_zero, p_max, p_one;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  odd_lut_cmul #(.W(W), .COEF(C_MAIN)) u_odd_lut_cmul    (.clk(clk), .rst_n(rst_n), .x(x), .prod(p_main));
  odd_lut_cmul #(.W(W), .COEF(C_ZERO)) u_odd_lut_cmul_c0 (.clk(clk), .rst_n(rst_n), .x(x), .prod(p_zero));
  odd_lut_cmul #(.W(W), .COEF(C_MAX))  u_odd_lut_cmul_cm (.clk(clk), .rst_n(rst_n), .x(x), .prod(p_max));
  odd_lut_cmul #(.W(W), .COEF(C_ONE))  u_odd_lut_cmul_c1 (.clk(clk), .rst_n(rst_n), .x(x), .prod(p_one));

  function automatic logic [PW-1:0] ref_mul(input logic [4:0] v, input logic [W-1:0] c);
    return PW'(PW'(v) * PW'(c));
  endfunction

  task automatic chk(input string req, input logic [4:0] v, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s x=%0d actual=%0d expected=%0d", req, v, act, exp);
    end
  endtask

  // operand on a falling edge, result read on the next falling edge
  task automatic drive(input logic [4:0] v);
    @(negedge clk) x = v;
    @(negedge clk);
  endtask

  task automatic t_reset_r2;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R2", x, p_main, '0);
      chk("R2", x, p_max, '0);
    end
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic t_odd_r3;
    for (int v = 1; v < 16; v += 2) begin
      drive(5'(v));
      chk("R3", 5'(v), p_main, ref_mul(5'(v), C_MAIN));
      chk("R3", 5'(v), p_one, PW'(v));
    end
  endtask

  task automatic t_even_r4;
    for (int v = 2; v < 16; v += 2) begin
      drive(5'(v));
      chk("R4", 5'(v), p_main, ref_mul(5'(v), C_MAIN));
      chk("R4", 5'(v), p_max, ref_mul(5'(v), C_MAX));
    end
  endtask

  task automatic t_zero_r5;
    drive(5'd31);
    drive(5'd0);
    chk("R5", 5'd0, p_main, '0);
    chk("R5", 5'd0, p_max, '0);
  endtask

  task automatic t_sixteen_r6;
    drive(5'd16);
    chk("R6", 5'd16, p_main, PW'(16 * 173));
    chk("R6", 5'd16, p_max, PW'(16 * 255));
  endtask

  task automatic t_fold_r7;
    for (int v = 17; v < 32; v++) begin
      drive(5'(v));
      chk("R7", 5'(v), p_main, PW'(32 * 173 - (32 - v) * 173));
      chk("R7", 5'(v), p_one, PW'(v));
    end
  endtask

  task automatic t_coef_r8;
    for (int v = 0; v < 32; v++) begin
      drive(5'(v));
      chk("R8", 5'(v), p_zero, '0);
      chk("R8", 5'(v), p_max, ref_mul(5'(v), C_MAX));
    end
  endtask

  task automatic t_sweep_r1;
    for (int v = 31; v >= 0; v--) begin
      drive(5'(v));
      chk("R1", 5'(v), p_main, ref_mul(5'(v), C_MAIN));
    end
    for (int v = 0; v < 32; v++) begin
      drive(5'((v * 13) % 32));
      chk("R1", 5'((v * 13) % 32), p_main, ref_mul(5'((v * 13) % 32), C_MAIN));
    end
  endtask

  initial begin
    t_reset_r2();
    t_odd_r3();
    t_even_r4();
    t_zero_r5();
    t_sixteen_r6();
    t_fold_r7();
    t_coef_r8();
    t_sweep_r1();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule